// File: doc/BRIEF.md
# Half-Bridge Output Enable Sequencer

This block decides, every clock, which of seven half-bridge power outputs may switch: one bias half-bridge and six audio half-bridges (lanes A to F, on `audio_en[0]` to `audio_en[5]`). A deasserted enable means that output is held in high impedance. The bias half-bridge runs first and charges the dc-blocking network. The audio lanes start only after the bias half-bridge has stopped. The two are never driven together.

The decision depends on four things. A 2-bit lane-count code selects three-lane operation, six-lane operation or a reserved setting. A preparation control and an active-low hold control select the phase. A fault-disable input from the protection logic overrides everything. All enables come from registers, so each one follows its inputs one clock later.

Top module: `hb_enable_seq`

## Requirements
- R1: While `rst_n` is low, every enable output is low. They remain low until the first clock edge after `rst_n` is released.
- R2: Each enable output shows the decision made on the inputs sampled at the previous rising clock edge.
- R3: With `prep`=0 and `hold_n`=0 in a legal mode, all seven enables are low.
- R4: With `prep`=1 and `hold_n`=0 in a legal mode, `bias_en` is high and every `audio_en` bit is low.
- R5: With lane code 2'b01 (six-lane), `prep`=1 and `hold_n`=1, all six `audio_en` bits are high and `bias_en` is low.
- R6: With lane code 2'b00 (three-lane), `prep`=0 and `hold_n`=1, `audio_en[2:0]` are high. `audio_en[5:3]` and `bias_en` are low.
- R7: The remaining control combinations in a legal mode turn all seven enables low. These are six-lane with `prep`=0, `hold_n`=1, and three-lane with `prep`=1, `hold_n`=1.
- R8: Lane codes 2'b10 and 2'b11 are reserved. With either one, all seven enables are low, whatever the controls are.
- R9: When `fault_off` is high, all seven enables are low on the next cycle, whatever the mode and controls are.
- R10: `bias_en` and any `audio_en` bit are never high in the same cycle. A move from bias phase to audio phase drops `bias_en` on the same edge that raises the audio enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low, clears all enables |
| mode | input | 2 | Lane-count code: 00 three-lane, 01 six-lane, 1x reserved |
| prep | input | 1 | Preparation control (bias phase request) |
| hold_n | input | 1 | Active-low hold of the power stage |
| fault_off | input | 1 | Fault disable from protection logic, active high |
| bias_en | output | 1 | Bias half-bridge enable, low means high impedance |
| audio_en | output | 6 | Audio half-bridge enables, bit 0 is lane A |

## Verification
Two events can land on the same clock edge: the end of the bias phase and the start of the audio phase. A fault can also arrive on the very edge where the audio phase would begin. The bench drives bias phase, then raises `hold_n` in six-lane mode, then in three-lane mode by dropping `prep` on the same cycle. On the edge of each switch it checks that the bias enable is already low while the audio enables are high, and that no sample shows both. A fault asserted together with the audio-start controls must produce an all-low result, not a brief audio pulse.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LC_BASE = 2'b00,
    LC_FULL = 2'b01
  } lane_code_t;

  typedef enum logic [1:0] {
    PH_OFF   = 2'b00,
    PH_BIAS  = 2'b01,
    PH_AUDIO = 2'b10
  } phase_t;

  // Phase selection from controls; legal = non-reserved code, full = six-lane
  function automatic phase_t pick_phase(input logic legal, input logic full,
                                        input logic prep, input logic hold_n,
                                        input logic fault);
    phase_t p;
    p = PH_OFF;
    if (legal && !fault) begin
      unique case ({prep, hold_n})
        2'b10:   p = PH_BIAS;
        2'b11:   p = full ? PH_AUDIO : PH_OFF;
        2'b01:   p = full ? PH_OFF : PH_AUDIO;
        default: p = PH_OFF;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/hb_lane_decode.sv
module hb_lane_decode #(
  parameter int NUM_LANES  = 6,
  parameter int BASE_LANES = 3
) (
  input  logic [1:0]           mode,
  output logic                 legal,
  output logic                 full,
  output logic [NUM_LANES-1:0] lane_mask
);
  import hb_pkg::*;

  localparam logic [NUM_LANES-1:0] FULL_MASK = {NUM_LANES{1'b1}};
  localparam logic [NUM_LANES-1:0] BASE_MASK = FULL_MASK >> (NUM_LANES - BASE_LANES);

  always_comb begin
    legal     = (mode[1] == 1'b0);
    full      = (mode == LC_FULL);
    lane_mask = full ? FULL_MASK : BASE_MASK;
  end
endmodule

// File: rtl/hb_phase_sel.sv
module hb_phase_sel (
  input  logic          legal,
  input  logic          full,
  input  logic          prep,
  input  logic          hold_n,
  input  logic          fault_off,
  output hb_pkg::phase_t phase_nxt
);
  import hb_pkg::*;

  always_comb phase_nxt = pick_phase(legal, full, prep, hold_n, fault_off);
endmodule

// File: rtl/hb_en_bank.sv
module hb_en_bank #(
  parameter int NUM_LANES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  hb_pkg::phase_t       phase_nxt,
  input  logic [NUM_LANES-1:0] lane_mask,
  output logic                 bias_en,
  output logic [NUM_LANES-1:0] audio_en
);
  import hb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bias_en <= 1'b0;
    else        bias_en <= (phase_nxt == PH_BIAS);
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) audio_en[g] <= 1'b0;
      else        audio_en[g] <= (phase_nxt == PH_AUDIO) && lane_mask[g];
    end
  end
endmodule

// File: rtl/hb_enable_seq.sv
module hb_enable_seq #(
  parameter int NUM_LANES  = 6,
  parameter int BASE_LANES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 prep,
  input  logic                 hold_n,
  input  logic                 fault_off,
  output logic                 bias_en,
  output logic [NUM_LANES-1:0] audio_en
);
  import hb_pkg::*;

  logic                 legal;
  logic                 full;
  logic [NUM_LANES-1:0] lane_mask;
  phase_t               phase_nxt;

  hb_lane_decode #(.NUM_LANES(NUM_LANES), .BASE_LANES(BASE_LANES)) u_dec (
    .mode(mode), .legal(legal), .full(full), .lane_mask(lane_mask)
  );

  hb_phase_sel u_sel (
    .legal(legal), .full(full), .prep(prep), .hold_n(hold_n),
    .fault_off(fault_off), .phase_nxt(phase_nxt)
  );

  hb_en_bank #(.NUM_LANES(NUM_LANES)) u_bank (
    .clk(clk), .rst_n(rst_n), .phase_nxt(phase_nxt), .lane_mask(lane_mask),
    .bias_en(bias_en), .audio_en(audio_en)
  );
endmodule

// File: rtl/hb_enable_seq_chk.sv
module hb_enable_seq_chk #(
  parameter int NUM_LANES  = 6,
  parameter int BASE_LANES = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic                 prep,
  input logic                 hold_n,
  input logic                 fault_off,
  input logic                 bias_en,
  input logic [NUM_LANES-1:0] audio_en,
  input hb_pkg::phase_t       phase_nxt
);
  import hb_pkg::*;

  always_comb if (!rst_n) AST_RESET_QUIET: assert (!bias_en && audio_en == '0); // R1

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(bias_en && |audio_en)); // R10

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_off |=> (!bias_en && audio_en == '0)); // R9

  AST_RESERVED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> (!bias_en && audio_en == '0)); // R8

  AST_BIAS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !fault_off && prep && !hold_n) |=> (bias_en && audio_en == '0)); // R4

  AST_BASE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (audio_en[NUM_LANES-1:BASE_LANES] == '0)); // R6

  AST_PHASE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_nxt == PH_AUDIO) |=> (!bias_en && audio_en[0])); // R2
endmodule

bind hb_enable_seq hb_enable_seq_chk #(.NUM_LANES(NUM_LANES), .BASE_LANES(BASE_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .prep(prep), .hold_n(hold_n),
  .fault_off(fault_off), .bias_en(bias_en), .audio_en(audio_en),
  .phase_nxt(phase_nxt)
);

// File: tb/hb_enable_seq_bench.sv
module hb_enable_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       prep = 1'b0;
  logic       hold_n = 1'b0;
  logic       fault_off = 1'b0;
  logic       bias_en;
  logic [5:0] audio_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       bias;
    logic [5:0] audio;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  hb_enable_seq u_hb_enable_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .prep(prep), .hold_n(hold_n),
    .fault_off(fault_off), .bias_en(bias_en), .audio_en(audio_en)
  );

  // Expected value from the requirement table
  task automatic apply(input logic [1:0] m, input logic p, input logic h,
                       input logic f, input string tag);
    exp_t e;
    @(negedge clk);
    mode = m; prep = p; hold_n = h; fault_off = f;
    e.bias = 1'b0; e.audio = 6'b0; e.tag = tag;
    if (!f && m == 2'b00) begin
      if (p && !h) e.bias = 1'b1;
      else if (!p && h) e.audio = 6'b000111;
    end else if (!f && m == 2'b01) begin
      if (p && !h) e.bias = 1'b1;
      else if (p && h) e.audio = 6'b111111;
    end
    sb.push_back(e);
  endtask

  // Monitor: compare one expected item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (bias_en !== e.bias || audio_en !== e.audio) begin
          errors++;
          $display("FAIL %s: bias=%b audio=%b expected bias=%b audio=%b",
                   e.tag, bias_en, audio_en, e.bias, e.audio);
        end
        if (bias_en === 1'b1 && audio_en !== 6'b0) begin
          checks++; errors++;
          $display("FAIL R10: bias=%b audio=%b expected no overlap", bias_en, audio_en);
        end
      end
    end
  end

  initial begin
    // R1: held in reset with bias request present
    mode = 2'b01; prep = 1'b1; hold_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bias_en !== 1'b0 || audio_en !== 6'b0) begin
      errors++;
      $display("FAIL R1: bias=%b audio=%b expected bias=0 audio=000000", bias_en, audio_en);
    end
    rst_n = 1'b1;
    #0.1;
    checks++;
    if (bias_en !== 1'b0 || audio_en !== 6'b0) begin
      errors++;
      $display("FAIL R1: after release bias=%b audio=%b expected 0/000000", bias_en, audio_en);
    end

    apply(2'b01, 1'b0, 1'b0, 1'b0, "R3 six-lane idle");
    apply(2'b01, 1'b1, 1'b0, 1'b0, "R4 six-lane bias");
    apply(2'b01, 1'b1, 1'b1, 1'b0, "R5 R10 bias to six audio");
    apply(2'b01, 1'b1, 1'b1, 1'b0, "R5 hold six audio");
    apply(2'b01, 1'b0, 1'b1, 1'b0, "R7 six-lane unlisted");
    apply(2'b00, 1'b0, 1'b0, 1'b0, "R3 three-lane idle");
    apply(2'b00, 1'b1, 1'b0, 1'b0, "R4 three-lane bias");
    apply(2'b00, 1'b0, 1'b1, 1'b0, "R6 R10 bias to three audio");
    apply(2'b00, 1'b1, 1'b1, 1'b0, "R7 three-lane unlisted");
    apply(2'b00, 1'b0, 1'b1, 1'b0, "R2 three audio again");
    apply(2'b01, 1'b1, 1'b1, 1'b0, "R2 one-cycle mode switch");
    apply(2'b10, 1'b1, 1'b0, 1'b0, "R8 reserved 10 bias request");
    apply(2'b11, 1'b1, 1'b1, 1'b0, "R8 reserved 11 audio request");
    apply(2'b10, 1'b0, 1'b1, 1'b0, "R8 reserved 10 three request");
    apply(2'b01, 1'b1, 1'b0, 1'b0, "R4 bias before fault");
    apply(2'b01, 1'b1, 1'b1, 1'b1, "R9 fault on audio start");
    apply(2'b00, 1'b1, 1'b0, 1'b1, "R9 fault on bias");
    apply(2'b00, 1'b0, 1'b1, 1'b1, "R9 fault on three audio");
    apply(2'b00, 1'b0, 1'b1, 1'b0, "R9 fault release");
    apply(2'b00, 1'b0, 1'b0, 1'b0, "R3 back to idle");
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule